// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block keeps a small VLAN membership table for an Ethernet switch. Each entry pairs a VLAN ID with a member-port mask and a valid bit. Software never addresses the table directly. It first writes a data register with the member mask and the valid bit for the entry. It then writes a command register with an opcode, a VLAN ID and a port number, with the active bit set. The engine carries out the command by walking the table one entry per clock cycle. When it has finished, it clears the active bit. A load that finds no room in the table raises a full flag.

The supported commands are flush (invalidate every entry), load (insert a new entry or update an existing one), purge (invalidate the entry for one VLAN ID) and remove-port (drop one port from every entry). A separate lookup port serves the forwarding logic. It returns the member mask and a hit flag for a presented VLAN ID one cycle later.

Top module: `vtab_engine`

## Requirements
- R1: After reset both register readbacks are zero and the active bit and the full flag are low. Every table entry is invalid, so no lookup hits.
- R2: The command register layout is: opcode in bits [2:0], active in bit 3, full in bit 4 (read-only), port number in [11:8], VLAN ID in [27:16], priority in [30:28] and priority enable in bit 31. All other bits read as zero. A write with bit 3 clear stores the fields but starts no command.
- R3: The data register holds the member mask in bits [9:0] and the entry-valid bit in bit 11. All other bits read as zero.
- R4: A load (opcode 2) whose VLAN ID matches a valid entry overwrites that entry with the data register contents. Otherwise it writes the lowest-indexed invalid entry.
- R5: A load with no matching entry and no invalid entry sets the full flag and leaves the table unchanged. Accepting any command clears the full flag.
- R6: Flush (opcode 1) makes every entry invalid.
- R7: Purge (opcode 3) invalidates only the entry whose VLAN ID matches. All other entries are left as they were.
- R8: Remove-port (opcode 4) clears the bit of the given port in the mask of every valid entry. A port number of 10 or more changes nothing.
- R9: Flush, load, purge and remove-port hold the active bit high for exactly 18 cycles. No-op (opcode 0) and opcodes 5 to 7 hold it high for 2 cycles and leave the table unchanged.
- R10: While the active bit is high, writes to the command register and to the data register are ignored.
- R11: The lookup outputs give the hit flag and the member mask one cycle after a VLAN ID is presented. An entry loaded with its valid bit clear never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 selects the command register, 1 selects the data register |
| reg_wdata | input | 32 | Register write data |
| cmd_rdata | output | 32 | Command register readback, including the active bit and the full flag |
| data_rdata | output | 32 | Data register readback |
| lk_vid | input | 12 | VLAN ID presented for lookup |
| lk_hit | output | 1 | A valid entry matched the VLAN ID from the previous cycle |
| lk_members | output | 10 | Member mask of the matching entry, zero on a miss |

## Verification
On every cycle, the assertions check the following:
- Command and data writes leave the stored fields unchanged while a command is running.
- The full flag rises only at the end of a load.
- A scan advances by exactly one entry per cycle.
- Completion is signalled only while the active bit is high.
- A lookup hit is only ever reported when some entry is valid.

Only the bench scenarios can show the table contents produced by each command. These include overwrite in place against fill of the lowest free slot, and the full condition on the seventeenth distinct ID. They also include the selective effect of purge and remove-port, the exact busy lengths, and invalid entries that never hit. The bench checks all of these against a reference model of the table.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam logic [2:0] OP_NOOP  = 3'd0;
  localparam logic [2:0] OP_FLUSH = 3'd1;
  localparam logic [2:0] OP_LOAD  = 3'd2;
  localparam logic [2:0] OP_PURGE = 3'd3;
  localparam logic [2:0] OP_RMPRT = 3'd4;

  localparam int CMD_ACT_BIT  = 3;
  localparam int CMD_FULL_BIT = 4;
  localparam int CMD_PORT_LSB = 8;
  localparam int CMD_VID_LSB  = 16;
  localparam int CMD_PRI_LSB  = 28;
  localparam int CMD_PEN_BIT  = 31;
  localparam int DAT_VAL_BIT  = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/vtab_regs.sv
module vtab_regs
  import vtab_pkg::*;
#(
  parameter int VID_W  = 12,
  parameter int PORTS  = 10,
  parameter int PNUM_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              seq_done,
  input  logic              seq_fail,
  output logic              active,
  output logic              start,
  output logic [2:0]        op_q,
  output logic [PNUM_W-1:0] port_q,
  output logic [VID_W-1:0]  vid_q,
  output logic [PORTS-1:0]  mem_q,
  output logic              val_q,
  output logic [31:0]       cmd_rdata,
  output logic [31:0]       data_rdata
);
  logic       full_q;
  logic [2:0] pri_q;
  logic       pen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      start  <= 1'b0;
      full_q <= 1'b0;
      op_q   <= '0;
      port_q <= '0;
      vid_q  <= '0;
      pri_q  <= '0;
      pen_q  <= 1'b0;
      mem_q  <= '0;
      val_q  <= 1'b0;
    end else begin
      start <= 1'b0;
      if (seq_done) begin
        active <= 1'b0;
        if (seq_fail) full_q <= 1'b1;
      end
      if (reg_wr && !active) begin
        if (!reg_sel) begin
          op_q   <= reg_wdata[2:0];
          port_q <= reg_wdata[CMD_PORT_LSB +: PNUM_W];
          vid_q  <= reg_wdata[CMD_VID_LSB +: VID_W];
          pri_q  <= reg_wdata[CMD_PRI_LSB +: 3];
          pen_q  <= reg_wdata[CMD_PEN_BIT];
          if (reg_wdata[CMD_ACT_BIT]) begin
            active <= 1'b1;
            start  <= 1'b1;
            full_q <= 1'b0;
          end
        end else begin
          mem_q <= reg_wdata[PORTS-1:0];
          val_q <= reg_wdata[DAT_VAL_BIT];
        end
      end
    end
  end

  always_comb begin
    cmd_rdata = '0;
    cmd_rdata[2:0] = op_q;
    cmd_rdata[CMD_ACT_BIT] = active;
    cmd_rdata[CMD_FULL_BIT] = full_q;
    cmd_rdata[CMD_PORT_LSB +: PNUM_W] = port_q;
    cmd_rdata[CMD_VID_LSB +: VID_W] = vid_q;
    cmd_rdata[CMD_PRI_LSB +: 3] = pri_q;
    cmd_rdata[CMD_PEN_BIT] = pen_q;
    data_rdata = '0;
    data_rdata[PORTS-1:0] = mem_q;
    data_rdata[DAT_VAL_BIT] = val_q;
  end

  // R10: register writes during a running command leave the fields alone
  a_r10_ignore_busy_writes: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && active) |=> ($stable(op_q) && $stable(vid_q) && $stable(port_q)
                            && $stable(mem_q) && $stable(val_q)));

  // R5: full only rises at the end of a load
  a_r5_full_from_load: assert property (@(posedge clk) disable iff (rst)
    $rose(full_q) |-> (op_q == OP_LOAD));
endmodule

// File: rtl/vtab_seq.sv
module vtab_seq
  import vtab_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int VID_W  = 12,
  parameter int PORTS  = 10,
  parameter int PNUM_W = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              active,
  input  logic [2:0]        op,
  input  logic [PNUM_W-1:0] port,
  input  logic [VID_W-1:0]  vid,
  input  logic [PORTS-1:0]  dat_mem,
  input  logic              dat_val,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [VID_W-1:0]  ent_vid,
  input  logic [PORTS-1:0]  ent_mem,
  input  logic              ent_val,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [VID_W-1:0]  wr_vid,
  output logic [PORTS-1:0]  wr_mem,
  output logic              wr_val,
  output logic              done,
  output logic              fail
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic             hit_f, free_f;
  logic [IDX_W-1:0] hit_i, free_i;
  logic             scan_op, vid_eq;
  logic [PORTS-1:0] pmask;

  assign scan_op = (op == OP_FLUSH) || (op == OP_LOAD) ||
                   (op == OP_PURGE) || (op == OP_RMPRT);
  assign vid_eq  = ent_val && (ent_vid == vid);
  assign pmask   = {{(PORTS-1){1'b0}}, 1'b1} << port;
  assign rd_idx  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      idx    <= '0;
      hit_f  <= 1'b0;
      free_f <= 1'b0;
      hit_i  <= '0;
      free_i <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          idx    <= '0;
          hit_f  <= 1'b0;
          free_f <= 1'b0;
          state  <= scan_op ? ST_SCAN : ST_FIN;
        end
        ST_SCAN: begin
          if (vid_eq && !hit_f) begin
            hit_f <= 1'b1;
            hit_i <= idx;
          end
          if (!ent_val && !free_f) begin
            free_f <= 1'b1;
            free_i <= idx;
          end
          idx <= idx + IDX_W'(1);
          if (idx == LAST) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = idx;
    wr_vid = ent_vid;
    wr_mem = ent_mem;
    wr_val = ent_val;
    if (state == ST_SCAN) begin
      case (op)
        OP_FLUSH: begin
          wr_en  = 1'b1;
          wr_val = 1'b0;
        end
        OP_PURGE: if (vid_eq) begin
          wr_en  = 1'b1;
          wr_val = 1'b0;
        end
        OP_RMPRT: if (ent_val && (pmask != '0)) begin
          wr_en  = 1'b1;
          wr_mem = ent_mem & ~pmask;
        end
        default: ;
      endcase
    end else if (state == ST_FIN && op == OP_LOAD) begin
      wr_vid = vid;
      wr_mem = dat_mem;
      wr_val = dat_val;
      if (hit_f) begin
        wr_en  = 1'b1;
        wr_idx = hit_i;
      end else if (free_f) begin
        wr_en  = 1'b1;
        wr_idx = free_i;
      end
    end
  end

  assign done = (state == ST_FIN);
  assign fail = done && (op == OP_LOAD) && !hit_f && !free_f;

  // R9: the scan visits exactly one entry per cycle
  a_r9_scan_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SCAN && idx != LAST) |=> (state == ST_SCAN && idx == $past(idx) + IDX_W'(1)));

  // R9: completion only while the command is flagged active
  a_r9_done_active: assert property (@(posedge clk) disable iff (rst)
    done |-> active);
endmodule

// File: rtl/vtab_store.sv
module vtab_store #(
  parameter int DEPTH = 16,
  parameter int VID_W = 12,
  parameter int PORTS = 10,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [VID_W-1:0] rd_vid,
  output logic [PORTS-1:0] rd_mem,
  output logic             rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [PORTS-1:0] wr_mem,
  input  logic             wr_val,
  input  logic [VID_W-1:0] lk_vid,
  output logic             lk_hit,
  output logic [PORTS-1:0] lk_members
);
  logic [VID_W-1:0] e_vid [DEPTH];
  logic [PORTS-1:0] e_mem [DEPTH];
  logic [DEPTH-1:0] e_val;
  logic             hit_c;
  logic [PORTS-1:0] mem_c;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      e_vid[wr_idx] <= wr_vid;
      e_mem[wr_idx] <= wr_mem;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) e_val <= '0;
    else if (wr_en) e_val[wr_idx] <= wr_val;
  end

  assign rd_vid = e_vid[rd_idx];
  assign rd_mem = e_mem[rd_idx];
  assign rd_val = e_val[rd_idx];

  always_comb begin
    hit_c = 1'b0;
    mem_c = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (e_val[i] && e_vid[i] == lk_vid) begin
        hit_c = 1'b1;
        mem_c = e_mem[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit     <= 1'b0;
      lk_members <= '0;
    end else begin
      lk_hit     <= hit_c;
      lk_members <= mem_c;
    end
  end

  // R11: a hit needs at least one valid entry in the previous cycle
  a_r11_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(|e_val));
endmodule

// File: rtl/vtab_engine.sv
module vtab_engine #(
  parameter int DEPTH = 16,
  parameter int VID_W = 12,
  parameter int PORTS = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      cmd_rdata,
  output logic [31:0]      data_rdata,
  input  logic [VID_W-1:0] lk_vid,
  output logic             lk_hit,
  output logic [PORTS-1:0] lk_members
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int PNUM_W = 4;

  logic              active, start, done, fail;
  logic [2:0]        op;
  logic [PNUM_W-1:0] port;
  logic [VID_W-1:0]  vid;
  logic [PORTS-1:0]  dmem;
  logic              dval;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [VID_W-1:0]  ent_vid, wr_vid;
  logic [PORTS-1:0]  ent_mem, wr_mem;
  logic              ent_val, wr_val, wr_en;

  vtab_regs #(.VID_W(VID_W), .PORTS(PORTS), .PNUM_W(PNUM_W)) regs_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .seq_done(done), .seq_fail(fail), .active(active), .start(start),
    .op_q(op), .port_q(port), .vid_q(vid), .mem_q(dmem), .val_q(dval),
    .cmd_rdata(cmd_rdata), .data_rdata(data_rdata)
  );

  vtab_seq #(.DEPTH(DEPTH), .VID_W(VID_W), .PORTS(PORTS), .PNUM_W(PNUM_W)) seq_i (
    .clk(clk), .rst(rst), .start(start), .active(active), .op(op), .port(port),
    .vid(vid), .dat_mem(dmem), .dat_val(dval), .rd_idx(rd_idx),
    .ent_vid(ent_vid), .ent_mem(ent_mem), .ent_val(ent_val),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vid(wr_vid), .wr_mem(wr_mem), .wr_val(wr_val),
    .done(done), .fail(fail)
  );

  vtab_store #(.DEPTH(DEPTH), .VID_W(VID_W), .PORTS(PORTS)) store_i (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_vid(ent_vid), .rd_mem(ent_mem),
    .rd_val(ent_val), .wr_en(wr_en), .wr_idx(wr_idx), .wr_vid(wr_vid),
    .wr_mem(wr_mem), .wr_val(wr_val), .lk_vid(lk_vid), .lk_hit(lk_hit),
    .lk_members(lk_members)
  );
endmodule

// File: tb/vtab_engine_tb_top.sv
module vtab_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] cmd_rdata, data_rdata;
  logic [11:0] lk_vid;
  logic        lk_hit;
  logic [9:0]  lk_members;

  int checks = 0;
  int fails  = 0;

  bit [11:0] m_vid [16];
  bit [9:0]  m_mem [16];
  bit        m_val [16];
  bit        m_full;
  bit [9:0]  d_mem;
  bit        d_val;

  always #10 clk = ~clk;

  vtab_engine dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .lk_vid(lk_vid),
    .lk_hit(lk_hit), .lk_members(lk_members)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_data(input bit [9:0] mem, input bit val);
    wr_reg(1'b1, {20'd0, val, 1'b0, mem});
    d_mem = mem; d_val = val;
  endtask

  task automatic model_cmd(input bit [2:0] op, input bit [11:0] vid, input bit [3:0] port);
    int hi, fi;
    m_full = 1'b0;
    case (op)
      3'd1: for (int i = 0; i < 16; i++) m_val[i] = 1'b0;
      3'd2: begin
        hi = -1; fi = -1;
        for (int i = 0; i < 16; i++) begin
          if (hi < 0 && m_val[i] && m_vid[i] == vid) hi = i;
          if (fi < 0 && !m_val[i]) fi = i;
        end
        if (hi < 0) hi = fi;
        if (hi < 0) m_full = 1'b1;
        else begin
          m_vid[hi] = vid; m_mem[hi] = d_mem; m_val[hi] = d_val;
        end
      end
      3'd3: for (int i = 0; i < 16; i++)
        if (m_val[i] && m_vid[i] == vid) m_val[i] = 1'b0;
      3'd4: if (port < 10) for (int i = 0; i < 16; i++)
        if (m_val[i]) m_mem[i][port] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic run_cmd(input bit [2:0] op, input bit [11:0] vid, input bit [3:0] port);
    logic [31:0] w;
    int cnt;
    int exp_cnt;
    w = '0; w[2:0] = op; w[3] = 1'b1; w[11:8] = port; w[27:16] = vid;
    wr_reg(1'b0, w);
    cnt = 0;
    while (cmd_rdata[3] && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    exp_cnt = (op >= 3'd1 && op <= 3'd4) ? 18 : 2;
    check("R9 busy cycles", cnt, exp_cnt);
    model_cmd(op, vid, port);
    check("R5 full flag", {31'd0, cmd_rdata[4]}, {31'd0, m_full});
  endtask

  task automatic look(input string req, input bit [11:0] vid);
    bit eh; bit [9:0] em;
    eh = 1'b0; em = '0;
    for (int i = 15; i >= 0; i--)
      if (m_val[i] && m_vid[i] == vid) begin eh = 1'b1; em = m_mem[i]; end
    @(negedge clk);
    lk_vid = vid;
    @(negedge clk);
    check(req, {21'd0, lk_hit, lk_members}, {21'd0, eh, em});
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    report();
  end

  initial begin
    int cnt;
    logic [31:0] snap;
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0; lk_vid = '0;
    for (int i = 0; i < 16; i++) begin m_val[i] = 0; m_vid[i] = 0; m_mem[i] = 0; end
    m_full = 0; d_mem = 0; d_val = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cmd readback", cmd_rdata, 32'h0);
    check("R1 data readback", data_rdata, 32'h0);
    look("R1 no hit after reset", 12'h000);

    // R2 field layout, write without active bit
    wr_reg(1'b0, 32'hF123_FAF5);
    check("R2 cmd layout", cmd_rdata, 32'hF123_0A05);
    @(negedge clk);
    check("R2 no start", {31'd0, cmd_rdata[3]}, 32'd0);

    // R3 data layout
    wr_reg(1'b1, 32'hFFFF_FFFF);
    check("R3 data layout", data_rdata, 32'h0000_0BFF);
    d_mem = 10'h3FF; d_val = 1'b1;

    // R4 load and overwrite
    set_data(10'h003, 1'b1); run_cmd(3'd2, 12'd5, 4'd0);
    set_data(10'h0F0, 1'b1); run_cmd(3'd2, 12'd7, 4'd0);
    look("R4 load vid5", 12'd5);
    look("R4 load vid7", 12'd7);
    set_data(10'h2AA, 1'b1); run_cmd(3'd2, 12'd5, 4'd0);
    look("R4 overwrite vid5", 12'd5);

    // R6 flush
    run_cmd(3'd1, 12'd0, 4'd0);
    look("R6 flush vid5", 12'd5);
    look("R6 flush vid7", 12'd7);

    // R5 fill and overflow
    for (int i = 0; i < 16; i++) begin
      set_data(10'(i + 1), 1'b1); run_cmd(3'd2, 12'(100 + i), 4'd0);
    end
    set_data(10'h155, 1'b1); run_cmd(3'd2, 12'd200, 4'd0);
    check("R5 full set", {31'd0, cmd_rdata[4]}, 32'd1);
    look("R5 rejected vid", 12'd200);
    look("R5 old entry kept", 12'd115);
    run_cmd(3'd2, 12'd103, 4'd0);
    look("R4 overwrite when table full", 12'd103);

    // R7 purge then refill
    run_cmd(3'd3, 12'd104, 4'd0);
    look("R7 purged", 12'd104);
    look("R7 neighbour kept", 12'd105);
    set_data(10'h011, 1'b1); run_cmd(3'd2, 12'd300, 4'd0);
    look("R4 fill freed slot", 12'd300);
    run_cmd(3'd2, 12'd301, 4'd0);
    check("R5 full again", {31'd0, cmd_rdata[4]}, 32'd1);

    // R8 remove port
    run_cmd(3'd4, 12'd0, 4'd0);
    look("R8 port0 removed", 12'd100);
    look("R8 port0 removed b", 12'd102);
    run_cmd(3'd4, 12'd0, 4'd12);
    look("R8 port12 no change", 12'd101);

    // R9 no-op and undefined opcodes
    run_cmd(3'd0, 12'd101, 4'd1);
    run_cmd(3'd6, 12'd101, 4'd1);
    look("R9 noop table unchanged", 12'd101);

    // R11 invalid entry never hits
    run_cmd(3'd1, 12'd0, 4'd0);
    set_data(10'h3FF, 1'b0); run_cmd(3'd2, 12'd42, 4'd0);
    look("R11 invalid entry no hit", 12'd42);

    // R10 writes during busy ignored
    set_data(10'h00F, 1'b1);
    wr_reg(1'b0, 32'h0001_0009);
    snap = cmd_rdata;
    wr_reg(1'b0, 32'h0777_030A);
    wr_reg(1'b1, 32'h0000_0800);
    cnt = 0;
    while (cmd_rdata[3] && cnt < 100) begin cnt++; @(negedge clk); end
    model_cmd(3'd1, 12'd1, 4'd0);
    check("R10 cmd unchanged", cmd_rdata, snap & 32'hFFFF_FFF7);
    check("R10 data unchanged", data_rdata, 32'h0000_080F);
    run_cmd(3'd2, 12'd9, 4'd0);
    look("R10 load uses old data", 12'd9);

    // random mix
    for (int n = 0; n < 250; n++) begin
      int r;
      bit [2:0] op;
      r = $urandom_range(0, 9);
      op = (r < 5) ? 3'd2 : (r < 7) ? 3'd3 : (r < 8) ? 3'd4 : (r < 9) ? 3'd0 : 3'd1;
      if (op == 3'd2 && $urandom_range(0, 3) == 0) op = 3'd1 + 3'd1;
      if ($urandom_range(0, 40) == 0) op = 3'd1;
      set_data(10'($urandom), ($urandom_range(0, 7) != 0));
      run_cmd(op, 12'($urandom_range(0, 20)), 4'($urandom_range(0, 11)));
      look("R11 random lookup", 12'($urandom_range(0, 20)));
    end

    report();
  end
endmodule